// File: doc/BRIEF.md
# Bus termination output-enable controller

This block sequences the output enables and drive levels of four shared, pulled-up control lines of an external bus: transfer start, bus busy, burst inhibit and transfer acknowledge. A bus cycle opens on a start request. It closes on one of three events: an acknowledge generated inside the block, an acknowledge sampled from outside, or a timeout. The block raises a one-cycle done pulse when the cycle closes.

The selected chip-select's termination mode, wait count and timeout are sampled when the cycle is accepted. Three modes are supported. In wait-state mode the block produces the acknowledge after a programmed number of cycles, and an earlier outside acknowledge still wins. In external mode the acknowledge driver is never enabled. In programmable-machine mode the acknowledge driver is held for the whole cycle. Pads, threshold sensing and address decoding are outside the block.

Top module: `bus_term_ctrl`

## Requirements
- R1: While a cycle is active and the device was bus master when the cycle was accepted, the transfer-start and busy enables are 1 for every cycle of it. Start is driven low only in cycle 0 and high afterwards; busy is driven low throughout. Cycle 0 is the first clock after acceptance.
- R2: While a cycle is active and the local controller was responding when the cycle was accepted, the burst-inhibit enable is 1 for every cycle of it, driven high.
- R3: With mode_i = 2'b01 (external acknowledge), the acknowledge enable stays 0 and the cycle ends in the cycle where ext_ack_i is 1.
- R4: With mode_i = 2'b00 (wait states) and count n > 0, the acknowledge is enabled and driven high in cycle n-1. It is driven low in cycle n, and done_o is 1 in cycle n.
- R5: With wait-state mode and n = 0, the acknowledge is enabled and driven low in cycle 0 with no preceding high cycle, and done_o is 1 in cycle 0.
- R6: In wait-state mode, ext_ack_i = 1 in a cycle k < n sets done_o in cycle k; the acknowledge is not enabled unless k = n-1.
- R7: With mode_i = 2'b10 or 2'b11 (programmable machine), the acknowledge is enabled in every cycle, driven low in cycle n, and the cycle ends at cycle n or at an earlier ext_ack_i.
- R8: In every cycle after the one with done_o, and while idle, all four enables, done_o and err_o are 0. ext_ack_i has no effect while idle.
- R9: done_o is 1 for exactly one cycle per bus cycle, and start_i is ignored while a cycle is active.
- R10: In external mode with no acknowledge, the cycle ends in cycle t, where t is the 8-bit timeout, with done_o and err_o both 1. err_o is 0 whenever the cycle ends on an acknowledge.
- R11: The mode, wait count, timeout, master and responder inputs are sampled only when a cycle is accepted; later changes to them do not affect that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to open a bus cycle |
| master_i | input | 1 | Device owns the bus |
| hit_i | input | 1 | Local controller responds to the access |
| mode_i | input | 2 | 00 wait states, 01 external ack, 1x programmable machine |
| wait_n_i | input | 4 | Wait count n |
| tmo_i | input | 8 | External-ack timeout in cycles |
| ext_ack_i | input | 1 | Sampled external acknowledge, active high |
| start_oe_o | output | 1 | Transfer-start output enable |
| start_lvl_o | output | 1 | Transfer-start drive level |
| busy_oe_o | output | 1 | Bus-busy output enable |
| busy_lvl_o | output | 1 | Bus-busy drive level |
| inh_oe_o | output | 1 | Burst-inhibit output enable |
| inh_lvl_o | output | 1 | Burst-inhibit drive level |
| ack_oe_o | output | 1 | Acknowledge output enable |
| ack_lvl_o | output | 1 | Acknowledge drive level (0 asserts) |
| done_o | output | 1 | Cycle-done pulse |
| err_o | output | 1 | Timeout flag, with done_o |

## Verification
The assertions assume ext_ack_i is a clean synchronous level, and that start_i is sampled at clock edges without glitches. They do not assume start_i stays low during a cycle. The stimulus changes every input half a period away from the rising edge. It sweeps all wait counts, every early-acknowledge position, and a range of timeouts up to the 8-bit maximum. It deliberately scrambles the configuration inputs and pulses start_i during active cycles.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    MODE_WAIT  = 2'b00,
    MODE_EXT   = 2'b01,
    MODE_PROG  = 2'b10,
    MODE_PROG2 = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  master;
    logic  hit;
  } cfg_t;
endpackage

// File: rtl/bt_seq.sv
module bt_seq
  import bt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WAIT_W = 4,
  parameter int TMO_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              master_i,
  input  logic              hit_i,
  input  logic [1:0]        mode_i,
  input  logic [WAIT_W-1:0] wait_n_i,
  input  logic [TMO_W-1:0]  tmo_i,
  input  logic              done_i,
  output logic              act_o,
  output logic [CNT_W-1:0]  cnt_o,
  output cfg_t              cfg_o,
  output logic [WAIT_W-1:0] wait_q_o,
  output logic [TMO_W-1:0]  tmo_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o    <= 1'b0;
      cnt_o    <= '0;
      cfg_o    <= '{mode: MODE_WAIT, master: 1'b0, hit: 1'b0};
      wait_q_o <= '0;
      tmo_q_o  <= '0;
    end else if (!act_o) begin
      if (start_i) begin
        act_o       <= 1'b1;
        cnt_o       <= '0;
        cfg_o.mode   <= mode_e'(mode_i);
        cfg_o.master <= master_i;
        cfg_o.hit    <= hit_i;
        wait_q_o    <= wait_n_i;
        tmo_q_o     <= tmo_i;
      end
    end else if (done_i) begin
      act_o <= 1'b0;
    end else begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/bt_term.sv
module bt_term
  import bt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WAIT_W = 4,
  parameter int TMO_W  = 8
) (
  input  logic              act_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  cfg_t              cfg_i,
  input  logic [WAIT_W-1:0] wait_q_i,
  input  logic [TMO_W-1:0]  tmo_q_i,
  input  logic              ext_ack_i,
  output logic              done_o,
  output logic              err_o,
  output logic              int_ack_o,
  output logic              pre_ack_o
);
  logic [CNT_W-1:0] n_ext;
  logic [CNT_W-1:0] t_ext;
  logic             at_n, at_pre, at_tmo, ext;

  assign n_ext  = CNT_W'(wait_q_i);
  assign t_ext  = CNT_W'(tmo_q_i);
  assign ext    = act_i && ext_ack_i;
  assign at_n   = act_i && (cnt_i == n_ext);
  assign at_pre = act_i && (n_ext != '0) && (cnt_i == n_ext - CNT_W'(1));
  assign at_tmo = act_i && (cnt_i == t_ext);

  always_comb begin
    done_o    = 1'b0;
    err_o     = 1'b0;
    int_ack_o = 1'b0;
    pre_ack_o = 1'b0;
    unique case (cfg_i.mode)
      MODE_WAIT: begin
        int_ack_o = at_n;
        pre_ack_o = at_pre;
        done_o    = at_n || ext;
      end
      MODE_EXT: begin
        done_o = ext || at_tmo;
        err_o  = at_tmo && !ext;
      end
      default: begin
        int_ack_o = at_n;
        done_o    = at_n || ext;
      end
    endcase
  end
endmodule

// File: rtl/bt_drv.sv
module bt_drv
  import bt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             act_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  cfg_t             cfg_i,
  input  logic             int_ack_i,
  input  logic             pre_ack_i,
  output logic             start_oe_o,
  output logic             start_lvl_o,
  output logic             busy_oe_o,
  output logic             busy_lvl_o,
  output logic             inh_oe_o,
  output logic             inh_lvl_o,
  output logic             ack_oe_o,
  output logic             ack_lvl_o
);
  assign start_oe_o  = act_i && cfg_i.master;
  assign start_lvl_o = !(act_i && (cnt_i == '0));
  assign busy_oe_o   = act_i && cfg_i.master;
  assign busy_lvl_o  = !act_i;
  assign inh_oe_o    = act_i && cfg_i.hit;
  assign inh_lvl_o   = 1'b1;
  assign ack_lvl_o   = !int_ack_i;

  always_comb begin
    unique case (cfg_i.mode)
      MODE_WAIT: ack_oe_o = int_ack_i || pre_ack_i;
      MODE_EXT:  ack_oe_o = 1'b0;
      default:   ack_oe_o = act_i;
    endcase
  end
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import bt_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int TMO_W  = 8,
  localparam int CNT_W = (WAIT_W > TMO_W) ? WAIT_W : TMO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              master_i,
  input  logic              hit_i,
  input  logic [1:0]        mode_i,
  input  logic [WAIT_W-1:0] wait_n_i,
  input  logic [TMO_W-1:0]  tmo_i,
  input  logic              ext_ack_i,
  output logic              start_oe_o,
  output logic              start_lvl_o,
  output logic              busy_oe_o,
  output logic              busy_lvl_o,
  output logic              inh_oe_o,
  output logic              inh_lvl_o,
  output logic              ack_oe_o,
  output logic              ack_lvl_o,
  output logic              done_o,
  output logic              err_o
);
  logic              act;
  logic [CNT_W-1:0]  cnt;
  cfg_t              cfg;
  logic [WAIT_W-1:0] wait_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              int_ack, pre_ack;

  bt_seq #(.CNT_W(CNT_W), .WAIT_W(WAIT_W), .TMO_W(TMO_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .master_i, .hit_i, .mode_i, .wait_n_i, .tmo_i,
    .done_i(done_o), .act_o(act), .cnt_o(cnt), .cfg_o(cfg),
    .wait_q_o(wait_q), .tmo_q_o(tmo_q)
  );

  bt_term #(.CNT_W(CNT_W), .WAIT_W(WAIT_W), .TMO_W(TMO_W)) u_term (
    .act_i(act), .cnt_i(cnt), .cfg_i(cfg), .wait_q_i(wait_q), .tmo_q_i(tmo_q),
    .ext_ack_i, .done_o, .err_o, .int_ack_o(int_ack), .pre_ack_o(pre_ack)
  );

  bt_drv #(.CNT_W(CNT_W)) u_drv (
    .act_i(act), .cnt_i(cnt), .cfg_i(cfg), .int_ack_i(int_ack),
    .pre_ack_i(pre_ack), .start_oe_o, .start_lvl_o, .busy_oe_o, .busy_lvl_o,
    .inh_oe_o, .inh_lvl_o, .ack_oe_o, .ack_lvl_o
  );
endmodule

// File: rtl/bt_chk.sv
module bt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_oe_o,
  input logic busy_oe_o,
  input logic inh_oe_o,
  input logic ack_oe_o,
  input logic ack_lvl_o,
  input logic done_o,
  input logic err_o
);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !(start_oe_o || busy_oe_o || inh_oe_o || ack_oe_o));

  // R10
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R4
  ack_low_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_lvl_o |-> ack_oe_o);

  // R7
  ack_low_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_lvl_o |-> done_o);
endmodule

bind bus_term_ctrl bt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_oe_o(start_oe_o), .busy_oe_o(busy_oe_o),
  .inh_oe_o(inh_oe_o), .ack_oe_o(ack_oe_o), .ack_lvl_o(ack_lvl_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_bus_term_ctrl.sv
module tb_bus_term_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, master_i = 1'b0, hit_i = 1'b0, ext_ack_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [3:0] wait_n_i = '0;
  logic [7:0] tmo_i = '0;
  logic start_oe_o, start_lvl_o, busy_oe_o, busy_lvl_o, inh_oe_o, inh_lvl_o;
  logic ack_oe_o, ack_lvl_o, done_o, err_o;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  bus_term_ctrl dut (.*);

  // {start_oe,start_lvl,busy_oe,busy_lvl,inh_oe,inh_lvl,ack_oe,ack_lvl,done,err}
  function automatic logic [9:0] outs();
    return {start_oe_o, start_lvl_o, busy_oe_o, busy_lvl_o, inh_oe_o, inh_lvl_o,
            ack_oe_o, ack_lvl_o, done_o, err_o};
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  localparam logic [9:0] IDLE = 10'b0101010100;

  // ackk < 0: no external ack; restart_at >= 0: pulse start in that cycle
  task automatic run(input logic [1:0] md, input int n, input int tmo, input int ackk,
                     input bit mst, input bit hit, input int restart_at, input string tag);
    bit fin = 1'b0;
    @(negedge clk_i);
    mode_i = md; wait_n_i = 4'(n); tmo_i = 8'(tmo);
    master_i = mst; hit_i = hit; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R11: scramble configuration after acceptance
    mode_i = ~md; wait_n_i = ~4'(n); tmo_i = ~8'(tmo); master_i = ~mst; hit_i = ~hit;
    for (int k = 0; k < 300 && !fin; k++) begin
      logic ext, dn, er, aoe, alv;
      if (k > 0) @(negedge clk_i);
      ext = (k == ackk);
      ext_ack_i = ext;
      start_i = (k == restart_at);
      #1;
      er = 1'b0; aoe = 1'b0; alv = 1'b1;
      if (md == 2'b00) begin
        dn  = (k == n) || ext;
        aoe = (k == n) || (n != 0 && k == n - 1);
        alv = !(k == n);
      end else if (md == 2'b01) begin
        dn = ext || (k == tmo);
        er = (k == tmo) && !ext;
      end else begin
        dn  = (k == n) || ext;
        aoe = 1'b1;
        alv = !(k == n);
      end
      // R1 R2 R11 checked in every cycle alongside the mode tag
      check($sformatf("%s/R1/R2/R11 cycle %0d", tag, k), outs(),
            {mst, k != 0, mst, 1'b0, hit, 1'b1, aoe, alv, dn, er});
      fin = dn;
    end
    @(negedge clk_i);
    start_i = 1'b0;
    ext_ack_i = 1'b1; // R8: ignored while idle
    #1;
    check({tag, "/R8/R9 after done"}, outs(), IDLE);
    @(negedge clk_i);
    ext_ack_i = 1'b0;
    #1;
    check({tag, "/R8 idle"}, outs(), IDLE);
  endtask

  initial begin
    #1;
    check("R8 reset", outs(), IDLE);
    #10 rst_ni = 1'b1;
    // wait-state mode: every n, every early ack position
    for (int n = 0; n < 16; n++) begin
      for (int a = -1; a < n; a++) begin
        string t;
        t = (n == 0) ? "R5" : (a >= 0 ? "R6" : "R4");
        run(2'b00, n, 0, a, (n + a) % 2 == 0, (n + a) % 3 != 0, -1, t);
      end
    end
    // external-ack mode
    for (int t = 0; t < 10; t++) begin
      for (int a = -1; a <= t; a++)
        run(2'b01, 0, t, a, a[0], t[0], -1, (a < 0) ? "R10" : "R3");
    end
    run(2'b01, 0, 255, -1, 1'b1, 1'b1, -1, "R10");
    run(2'b01, 0, 40, 17, 1'b0, 1'b1, -1, "R3");
    // programmable-machine mode, both encodings
    for (int n = 0; n < 16; n++) begin
      run(2'b10, n, 0, -1, n[0], !n[0], -1, "R7");
      run(2'b11, n, 0, n / 2 - 1, !n[0], n[0], -1, "R7");
    end
    // start pulses inside active cycles
    run(2'b00, 9, 0, -1, 1'b1, 1'b1, 3, "R9");
    run(2'b01, 0, 12, -1, 1'b1, 1'b0, 0, "R9");
    run(2'b10, 5, 0, -1, 1'b0, 1'b1, 5, "R9");
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule